// File: doc/BRIEF.md
# Load-Use Hazard Detection Unit

This block lives in the decode stage of a five-stage in-order pipeline. It compares the source registers of the instruction now in decode with the destination of the instruction now in execute. When that instruction in execute is a memory read, it writes a register other than zero, and a source that decode actually consumes names that register, the unit stalls for one cycle. The value from memory exists only at the end of the memory stage, but the consumer would need it at the start of its own execute stage in that same cycle. No forwarding path can close that gap. Every other dependency is left to forwarding and causes no stall: an ALU result used by the next instruction, an ALU result stored by the next instruction, and a load whose consumer comes two or more instructions later.

While it stalls, the unit stops the PC and the IF/ID register from updating. It also forces the write-back, memory-read and memory-write controls entering ID/EX to zero, so the slot becomes a bubble. One cycle later the load has moved on to the memory stage and the condition clears by itself, without a counter. The consumer then picks up the loaded value from the MEM/WB forwarding path.

A thin wrapper holds the PC, the IF/ID register and the control half of the ID/EX register around the detector. This lets the detector's effect be observed cycle by cycle at the ports.

Top module: `hzd_pipe_ctrl`

## Requirements
- R1: A stall is raised when ID/EX holds a memory read whose destination is non-zero and equals the decode-stage first source, with that source flagged as used.
- R2: A stall is raised under the same conditions when the matching register is the decode-stage second source, flagged as used.
- R3: A source whose use flag is 0 never causes a stall, even when its register number matches the load destination.
- R4: A load whose destination is register 0 never causes a stall.
- R5: An instruction in execute that is not a memory read causes no stall. This includes an ALU result consumed by the next ALU operation or used as store data.
- R6: In a stall cycle, pc_wr_en and ifid_wr_en are 0 and bubble is 1, and the PC value is unchanged at the next edge. In every other cycle, pc_wr_en and ifid_wr_en are 1 and bubble is 0.
- R7: At the edge ending a stall, ID/EX captures reg_write, mem_read and mem_write as 0. At the following edge, ID/EX captures the held decode instruction with its own destination and controls.
- R8: Each adjacent load-use pair costs exactly one stall cycle, and no two consecutive cycles stall. The sequence load, load, add-using-both costs one stall in total. A load whose consumer is two instructions later costs none.
- R9: With rst_n low at a clock edge, the PC becomes 0 and the ID/EX controls become 0. After that edge, pc_wr_en = 1, ifid_wr_en = 1 and bubble = 0.
- R10: Every non-stall cycle advances the PC by PC_STEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| if_rs | input | REG_AW | First source register of the fetched instruction |
| if_rt | input | REG_AW | Second source register of the fetched instruction |
| if_rd | input | REG_AW | Destination register of the fetched instruction |
| if_rs_used | input | 1 | Fetched instruction reads its first source |
| if_rt_used | input | 1 | Fetched instruction reads its second source |
| if_reg_write | input | 1 | Fetched instruction writes a register |
| if_mem_read | input | 1 | Fetched instruction is a load |
| if_mem_write | input | 1 | Fetched instruction is a store |
| pc | output | PC_W | Current program counter |
| pc_wr_en | output | 1 | PC update enable (0 during a stall) |
| ifid_wr_en | output | 1 | IF/ID update enable (0 during a stall) |
| bubble | output | 1 | Controls entering ID/EX are forced to zero this cycle |
| ex_rd | output | REG_AW | Destination held in ID/EX |
| ex_reg_write | output | 1 | Register-write control held in ID/EX |
| ex_mem_read | output | 1 | Memory-read control held in ID/EX |
| ex_mem_write | output | 1 | Memory-write control held in ID/EX |

## Verification
The assertions take the fetched instruction fields as known values at every clock edge. They also take a store or a plain ALU operation to arrive with mem_read low. Under those conditions, a bubble can never follow a bubble, because the squashed slot carries no memory read. The bench drives only well-formed instructions built by helper functions: loads, ALU operations, stores and register-immediate forms. Register numbers are drawn from a small range so that matches, register-0 destinations and unused-source matches come up often, and a load-use stall can then never meet unknown inputs.

// File: rtl/hzd_pkg.sv
// Package: shared widths and record types for the load-use hazard block.
// Assumes a register file addressed by REG_AW bits with register 0 hard-wired.
package hzd_pkg;

    parameter int unsigned REG_AW = 5;

    typedef logic [REG_AW-1:0] reg_idx_t;

    // Control bits that a bubble must neutralise.
    typedef struct packed {
        logic reg_write;
        logic mem_read;
        logic mem_write;
    } ctrl_t;

    // Decoded instruction as held in IF/ID.
    typedef struct packed {
        reg_idx_t rs;
        reg_idx_t rt;
        reg_idx_t rd;
        logic     rs_used;
        logic     rt_used;
        ctrl_t    ctrl;
    } instr_t;

    // Fields of ID/EX that the hazard logic looks at.
    typedef struct packed {
        reg_idx_t rd;
        ctrl_t    ctrl;
    } ex_entry_t;

    localparam int unsigned INSTR_W = $bits(instr_t);
    localparam int unsigned EX_W    = $bits(ex_entry_t);

endpackage

// File: rtl/hzd_stage_reg.sv
// Module: hzd_stage_reg
// Generic pipeline register with write enable and synchronous active-low
// reset to zero. Assumes the all-zero pattern is a harmless no-op word.
module hzd_stage_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture d when enabled; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/hzd_load_use_detect.sv
// Module: hzd_load_use_detect
// Purely combinational comparison of the decode-stage sources against the
// destination of a load sitting in execute. Assumes register 0 is never
// really written, so a load to it cannot create a dependency.
module hzd_load_use_detect
    import hzd_pkg::*;
#(
    parameter int unsigned N_SRC = 2
) (
    input  reg_idx_t         src_idx  [N_SRC],
    input  logic [N_SRC-1:0] src_used,
    input  logic             ex_mem_read,
    input  reg_idx_t         ex_rd,
    output logic             stall
);

    logic [N_SRC-1:0] src_hit;
    logic             ex_load_live;

    // A load in execute only matters if it targets a real register.
    always_comb ex_load_live = ex_mem_read && (ex_rd != '0);

    // One comparator per source operand.
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        always_comb src_hit[s] = src_used[s] && (src_idx[s] == ex_rd);
    end

    // Any used source matching a live load requests the stall.
    always_comb stall = ex_load_live && (|src_hit);

endmodule

// File: rtl/hzd_ctrl_squash.sv
// Module: hzd_ctrl_squash
// Forces the side-effecting control bits to zero when a bubble is inserted.
// Assumes all state-changing controls are carried in ctrl_t.
module hzd_ctrl_squash
    import hzd_pkg::*;
(
    input  ctrl_t ctrl_in,
    input  logic  squash,
    output ctrl_t ctrl_out
);

    // Pass the controls through or replace them with a no-op set.
    always_comb begin
        ctrl_out = ctrl_in;
        if (squash) begin
            ctrl_out.reg_write = 1'b0;
            ctrl_out.mem_read  = 1'b0;
            ctrl_out.mem_write = 1'b0;
        end
    end

endmodule

// File: rtl/hzd_pipe_ctrl.sv
// Module: hzd_pipe_ctrl
// Decode-stage load-use interlock with the minimal pipeline state around it:
// PC, IF/ID and the control half of ID/EX. One bubble per adjacent load-use
// pair; the stall ends on its own when the load leaves execute.
// Assumes fetched fields are valid every cycle and stores/ALU ops arrive with
// mem_read low.
module hzd_pipe_ctrl
    import hzd_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] if_rs,
    input  logic [REG_AW-1:0] if_rt,
    input  logic [REG_AW-1:0] if_rd,
    input  logic              if_rs_used,
    input  logic              if_rt_used,
    input  logic              if_reg_write,
    input  logic              if_mem_read,
    input  logic              if_mem_write,
    output logic [PC_W-1:0]   pc,
    output logic              pc_wr_en,
    output logic              ifid_wr_en,
    output logic              bubble,
    output logic [REG_AW-1:0] ex_rd,
    output logic              ex_reg_write,
    output logic              ex_mem_read,
    output logic              ex_mem_write
);

    localparam int unsigned N_SRC = 2;
    localparam logic [PC_W-1:0] PC_INC = PC_W'(PC_STEP);

    instr_t    if_instr;
    instr_t    id_instr;
    ex_entry_t ex_next;
    ex_entry_t ex_q;
    ctrl_t     id_ctrl_sq;
    logic      stall;
    reg_idx_t  id_src [N_SRC];
    logic [N_SRC-1:0] id_src_used;
    logic [INSTR_W-1:0] id_vec;
    logic [EX_W-1:0]    ex_vec;

    // Pack the fetched fields into one record.
    always_comb begin
        if_instr.rs             = if_rs;
        if_instr.rt             = if_rt;
        if_instr.rd             = if_rd;
        if_instr.rs_used        = if_rs_used;
        if_instr.rt_used        = if_rt_used;
        if_instr.ctrl.reg_write = if_reg_write;
        if_instr.ctrl.mem_read  = if_mem_read;
        if_instr.ctrl.mem_write = if_mem_write;
    end

    // Program counter: advance unless the interlock holds it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (pc_wr_en) begin
            pc <= pc + PC_INC;
        end
    end

    // IF/ID register, frozen during a stall.
    hzd_stage_reg #(.W(INSTR_W)) u_ifid (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ifid_wr_en),
        .d     (INSTR_W'(if_instr)),
        .q     (id_vec)
    );

    // Unpack decode record and present the sources to the detector.
    always_comb begin
        id_instr       = instr_t'(id_vec);
        id_src[0]      = id_instr.rs;
        id_src[1]      = id_instr.rt;
        id_src_used[0] = id_instr.rs_used;
        id_src_used[1] = id_instr.rt_used;
    end

    hzd_load_use_detect #(.N_SRC(N_SRC)) u_detect (
        .src_idx     (id_src),
        .src_used    (id_src_used),
        .ex_mem_read (ex_q.ctrl.mem_read),
        .ex_rd       (ex_q.rd),
        .stall       (stall)
    );

    hzd_ctrl_squash u_squash (
        .ctrl_in  (id_instr.ctrl),
        .squash   (stall),
        .ctrl_out (id_ctrl_sq)
    );

    // Next ID/EX content: decode destination with possibly squashed controls.
    always_comb begin
        ex_next.rd   = id_instr.rd;
        ex_next.ctrl = id_ctrl_sq;
    end

    // ID/EX register, written every cycle.
    hzd_stage_reg #(.W(EX_W)) u_idex (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (1'b1),
        .d     (EX_W'(ex_next)),
        .q     (ex_vec)
    );

    // Drive stall outputs and expose the ID/EX record.
    always_comb begin
        ex_q         = ex_entry_t'(ex_vec);
        pc_wr_en     = !stall;
        ifid_wr_en   = !stall;
        bubble       = stall;
        ex_rd        = ex_q.rd;
        ex_reg_write = ex_q.ctrl.reg_write;
        ex_mem_read  = ex_q.ctrl.mem_read;
        ex_mem_write = ex_q.ctrl.mem_write;
    end

    // ---------------- assertions ----------------
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !ex_reg_write && !ex_mem_read && !ex_mem_write && !bubble));

    assert_pc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> $stable(pc));

    assert_pc_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble |=> (pc == $past(pc) + PC_INC));

    assert_bubble_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (!ex_reg_write && !ex_mem_read && !ex_mem_write));

    assert_ifid_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> $stable(id_vec));

    assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble);

    assert_r0_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0) |-> !bubble);

    assert_non_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_mem_read |-> !bubble);

    assert_unused_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_instr.rs_used && !id_instr.rt_used) |-> !bubble);

endmodule

// File: tb/hzd_pipe_ctrl_tb.sv
// Bench for hzd_pipe_ctrl: directed programs plus a seeded random program,
// each cycle compared with a reference model kept in the bench.
module hzd_pipe_ctrl_tb_top;
    import hzd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 32;
    localparam int PC_STEP    = 4;
    localparam int PROG_MAX   = 2100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [REG_AW-1:0] if_rs, if_rt, if_rd;
    logic if_rs_used, if_rt_used, if_reg_write, if_mem_read, if_mem_write;
    logic [PC_W-1:0] pc;
    logic pc_wr_en, ifid_wr_en, bubble;
    logic [REG_AW-1:0] ex_rd;
    logic ex_reg_write, ex_mem_read, ex_mem_write;

    int n_vec = 0;
    int n_fail = 0;
    bit done = 1'b0;

    instr_t prog [PROG_MAX];
    instr_t m_ifid;
    ex_entry_t m_idex;
    int m_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    hzd_pipe_ctrl #(.PC_W(PC_W), .PC_STEP(PC_STEP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .if_rs(if_rs), .if_rt(if_rt), .if_rd(if_rd),
        .if_rs_used(if_rs_used), .if_rt_used(if_rt_used),
        .if_reg_write(if_reg_write), .if_mem_read(if_mem_read), .if_mem_write(if_mem_write),
        .pc(pc), .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en), .bubble(bubble),
        .ex_rd(ex_rd), .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read),
        .ex_mem_write(ex_mem_write)
    );

    // Instruction builders.
    function automatic instr_t mk_alu(int rd, int rs, int rt);
        instr_t i = '0;
        i.rd = reg_idx_t'(rd); i.rs = reg_idx_t'(rs); i.rt = reg_idx_t'(rt);
        i.rs_used = 1'b1; i.rt_used = 1'b1; i.ctrl.reg_write = 1'b1;
        return i;
    endfunction
    function automatic instr_t mk_imm(int rd, int rs, int rt_junk);
        instr_t i = '0;
        i.rd = reg_idx_t'(rd); i.rs = reg_idx_t'(rs); i.rt = reg_idx_t'(rt_junk);
        i.rs_used = 1'b1; i.ctrl.reg_write = 1'b1;
        return i;
    endfunction
    function automatic instr_t mk_load(int rd, int base);
        instr_t i = mk_imm(rd, base, 0);
        i.ctrl.mem_read = 1'b1;
        return i;
    endfunction
    function automatic instr_t mk_store(int base, int data);
        instr_t i = '0;
        i.rs = reg_idx_t'(base); i.rt = reg_idx_t'(data);
        i.rs_used = 1'b1; i.rt_used = 1'b1; i.ctrl.mem_write = 1'b1;
        return i;
    endfunction

    // Stall rule from R1 to R5.
    function automatic bit exp_stall(instr_t id, ex_entry_t ex);
        return ex.ctrl.mem_read && ex.rd != '0 &&
               ((id.rs_used && id.rs == ex.rd) || (id.rt_used && id.rt == ex.rd));
    endfunction

    // Stall count predicted from the program text alone (R8).
    function automatic int count_pairs(int n);
        int c = 0;
        for (int k = 0; k + 1 < n; k++) begin
            ex_entry_t e;
            e.rd = prog[k].rd; e.ctrl = prog[k].ctrl;
            if (exp_stall(prog[k+1], e)) c++;
        end
        return c;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(instr_t i);
        if_rs = i.rs; if_rt = i.rt; if_rd = i.rd;
        if_rs_used = i.rs_used; if_rt_used = i.rt_used;
        if_reg_write = i.ctrl.reg_write; if_mem_read = i.ctrl.mem_read;
        if_mem_write = i.ctrl.mem_write;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive('0);
        @(negedge clk);
        #1;
        chk(pc == '0, "R9", "pc after reset", int'(pc), 0);
        chk(pc_wr_en && ifid_wr_en && !bubble, "R9", "stall outputs after reset",
            int'({pc_wr_en, ifid_wr_en, bubble}), 6);
        chk(!ex_reg_write && !ex_mem_read && !ex_mem_write, "R9", "ID/EX controls after reset",
            int'({ex_reg_write, ex_mem_read, ex_mem_write}), 0);
        rst_n = 1'b1;
        m_ifid = '0; m_idex = '0; m_idx = 0;
    endtask

    // Run prog[0..n-1] followed by no-ops, compare every cycle.
    task automatic run(int n, int exp_stalls, string tag);
        int bubbles = 0;
        int cyc = 0;
        while (m_idx < n + 3) begin
            instr_t f;
            bit s;
            f = (m_idx < n) ? prog[m_idx] : instr_t'('0);
            drive(f);
            #1;
            s = exp_stall(m_ifid, m_idex);
            chk(bubble == s, "R1/R2/R3/R4/R5", {tag, " bubble"}, int'(bubble), int'(s));
            chk(pc_wr_en == !s && ifid_wr_en == !s, "R6", {tag, " write enables"},
                int'({pc_wr_en, ifid_wr_en}), s ? 0 : 3);
            chk(pc == PC_W'(m_idx * PC_STEP), "R10", {tag, " pc"}, int'(pc), m_idx * PC_STEP);
            chk(ex_rd == m_idex.rd &&
                {ex_reg_write, ex_mem_read, ex_mem_write} == m_idex.ctrl, "R7",
                {tag, " ID/EX content"}, int'({ex_rd, ex_reg_write, ex_mem_read, ex_mem_write}),
                int'({m_idex.rd, m_idex.ctrl}));
            if (bubble) bubbles++;
            // reference update for the coming edge
            m_idex.rd = m_ifid.rd;
            m_idex.ctrl = s ? ctrl_t'('0) : m_ifid.ctrl;
            if (!s) begin
                m_ifid = f;
                m_idx++;
            end
            cyc++;
            @(negedge clk);
        end
        chk(bubbles == exp_stalls, "R8", {tag, " stall total"}, bubbles, exp_stalls);
    endtask

    initial begin
        drive('0);
        void'($urandom(32'd20240613));

        // R1: load then use as first source
        do_reset();
        prog[0] = mk_load(2, 1); prog[1] = mk_alu(3, 2, 1);
        run(2, 1, "R1 rs match");

        // R2: load then use as second source
        do_reset();
        prog[0] = mk_load(2, 1); prog[1] = mk_alu(3, 1, 2);
        run(2, 1, "R2 rt match");

        // R3: matching rt field not used
        do_reset();
        prog[0] = mk_load(2, 1); prog[1] = mk_imm(3, 1, 2);
        run(2, 0, "R3 unused rt");

        // R4: load to register 0
        do_reset();
        prog[0] = mk_load(0, 1); prog[1] = mk_alu(3, 0, 0);
        run(2, 0, "R4 r0 dest");

        // R5: ALU to ALU, ALU to store data
        do_reset();
        prog[0] = mk_alu(2, 1, 1); prog[1] = mk_alu(3, 2, 1); prog[2] = mk_store(1, 3);
        run(3, 0, "R5 alu chain");

        // R8: consumer two apart
        do_reset();
        prog[0] = mk_load(2, 1); prog[1] = mk_alu(5, 6, 7); prog[2] = mk_alu(3, 2, 2);
        run(3, 0, "R8 gap of one");

        // R8: load, load, add both
        do_reset();
        prog[0] = mk_load(2, 1); prog[1] = mk_load(3, 1); prog[2] = mk_alu(4, 2, 3);
        run(3, 1, "R8 two loads");

        // R8: back-to-back load-use pairs, address depends on load
        do_reset();
        prog[0] = mk_load(2, 1); prog[1] = mk_load(3, 2); prog[2] = mk_store(3, 3);
        run(3, 2, "R8 chained loads");

        // Random program with a small register range
        do_reset();
        for (int k = 0; k < 2000; k++) begin
            int kind = int'($urandom_range(0, 3));
            int a = int'($urandom_range(0, 3));
            int b = int'($urandom_range(0, 3));
            int c = int'($urandom_range(0, 3));
            case (kind)
                0: prog[k] = mk_load(a, b);
                1: prog[k] = mk_alu(a, b, c);
                2: prog[k] = mk_imm(a, b, c);
                default: prog[k] = mk_store(b, c);
            endcase
        end
        run(2000, count_pairs(2000), "random");

        // reset in the middle of a stall
        do_reset();
        prog[0] = mk_load(2, 1); prog[1] = mk_alu(3, 2, 1);
        drive(prog[0]); @(negedge clk);
        drive(prog[1]); @(negedge clk);
        #1;
        chk(bubble == 1'b1, "R1", "stall before reset", int'(bubble), 1);
        do_reset();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule